// File: doc/BRIEF.md
# RTC Status and Write-Enable Register

This block is the volatile status byte of a real-time clock. It holds sticky flags for two alarm comparators, mirrors whether the device runs on its backup supply, and records that all power was lost. It also holds two write-enable latches. Writes to memory are allowed while the first latch is set. Writes to clock and control registers are allowed only while both latches are set.

A protocol front end drives the block. It presents host writes of the status byte, and it brackets each status read with a start strobe and a completion strobe. The completion strobe stands for the end of the last data bit. Only the alarm flags that were already set when the read began are cleared when it completes. An alarm that arrives during the read survives it. The latches change only on exact write codes, so a stray byte cannot open write access.

Top module: `rtc_status_wel`

## Requirements
- R1: After reset, the status byte reads 0x00 (with the backup input low), and both permission outputs are low.
- R2: Bit 7 of the read byte always equals `on_backup_i`. Bits 4 and 3 always read 0.
- R3: A high `alarm_match_i[k]` sets alarm flag k on the next edge. Alarm 1 is read on bit 6 and alarm 0 on bit 5. A flag stays set until a read clears it.
- R4: On `rd_done_i`, the block clears only the flags captured at the last `rd_start_i`. A flag set after that start, or by a match in the same cycle as the completion, stays set. A completion with no preceding start clears nothing.
- R5: The write-enable latch (read on bit 1) is set only by a write of 0x02.
- R6: A write of 0x00 clears both latches.
- R7: The register write-enable latch (read on bit 2) is set by a write of 0x04, but only while the write-enable latch is already set.
- R8: A write of any other value leaves both latches unchanged. Host writes never change the alarm, backup or clock-fail bits.
- R9: `mem_wr_ok_o` equals the write-enable latch. `ctl_wr_ok_o` is high only when both latches are set.
- R10: A `cold_boot_i` pulse sets the clock-fail flag (bit 0) and clears both latches.
- R11: `rtc_wr_i` clears the clock-fail flag only while `ctl_wr_ok_o` is high. If `cold_boot_i` arrives in the same cycle, the flag is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low power-up reset |
| wr_en_i | input | 1 | Host write of the status byte |
| wr_data_i | input | 8 | Byte written by the host |
| rd_start_i | input | 1 | Status read begins |
| rd_done_i | input | 1 | Last data bit of status read finished |
| alarm_match_i | input | 2 | Alarm comparator matches |
| on_backup_i | input | 1 | Device runs from backup supply |
| cold_boot_i | input | 1 | Power-up after total power loss |
| rtc_wr_i | input | 1 | Write to a clock register attempted |
| rd_data_o | output | 8 | Current status byte |
| mem_wr_ok_o | output | 1 | Memory writes permitted |
| ctl_wr_ok_o | output | 1 | Clock/control writes permitted |

## Verification
The block has no parameters, so the bench builds it as it stands. Random write codes are weighted toward 0x00, 0x02, 0x04 and 0x06 and mixed with arbitrary bytes. This covers every latch transition, including the rejected register-enable write while the write-enable latch is low. Random read strobes overlap alarm matches. This produces the cases where a start and a match, or a completion and a match, share a cycle.

// File: rtl/rtc_status_wel.sv
module rtc_status_wel (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en_i,
  input  logic [7:0] wr_data_i,
  input  logic       rd_start_i,
  input  logic       rd_done_i,
  input  logic [1:0] alarm_match_i,
  input  logic       on_backup_i,
  input  logic       cold_boot_i,
  input  logic       rtc_wr_i,
  output logic [7:0] rd_data_o,
  output logic       mem_wr_ok_o,
  output logic       ctl_wr_ok_o
);
  logic       wel, rwel, fail;
  logic [1:0] alarm, mask;
  logic [1:0] clr;

  assign clr         = rd_done_i ? mask : 2'b00;
  assign mem_wr_ok_o = wel;
  assign ctl_wr_ok_o = wel & rwel;
  assign rd_data_o   = {on_backup_i, alarm[1], alarm[0], 2'b00, rwel, wel, fail};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wel  <= 1'b0;
      rwel <= 1'b0;
    end else if (cold_boot_i) begin
      wel  <= 1'b0;
      rwel <= 1'b0;
    end else if (wr_en_i) begin
      case (wr_data_i)
        8'h00: begin wel <= 1'b0; rwel <= 1'b0; end
        8'h02: wel <= 1'b1;
        8'h04: if (wel) rwel <= 1'b1;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      alarm <= 2'b00;
      mask  <= 2'b00;
    end else begin
      alarm <= (alarm & ~clr) | alarm_match_i;
      if (rd_start_i)     mask <= alarm;
      else if (rd_done_i) mask <= 2'b00;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    fail <= 1'b0;
    else if (cold_boot_i)          fail <= 1'b1;
    else if (rtc_wr_i && wel && rwel) fail <= 1'b0;
  end
endmodule

// File: rtl/rtc_status_wel_chk.sv
module rtc_status_wel_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_en_i,
  input logic [7:0] wr_data_i,
  input logic       rd_done_i,
  input logic [1:0] alarm_match_i,
  input logic       cold_boot_i,
  input logic       rtc_wr_i,
  input logic [7:0] rd_data_o,
  input logic       mem_wr_ok_o,
  input logic       ctl_wr_ok_o
);
  a_r3_alarm_sets: assert property (@(posedge clk) disable iff (!rst_n)
    alarm_match_i[0] |=> rd_data_o[5]);

  a_r4_sticky_without_done: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data_o[6] && !rd_done_i) |=> rd_data_o[6]);

  a_r5_wel_only_by_code: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_wr_ok_o && !(wr_en_i && wr_data_i == 8'h02)) |=> !mem_wr_ok_o);

  a_r8_other_codes_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && wr_data_i != 8'h00 && wr_data_i != 8'h02 && wr_data_i != 8'h04 && !cold_boot_i)
    |=> $stable(rd_data_o[2:1]));

  a_r9_ctl_needs_mem: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_wr_ok_o |-> mem_wr_ok_o);

  a_r10_boot_sets_fail: assert property (@(posedge clk) disable iff (!rst_n)
    cold_boot_i |=> (rd_data_o[0] && !mem_wr_ok_o));

  a_r11_fail_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data_o[0] && !(rtc_wr_i && ctl_wr_ok_o)) |=> rd_data_o[0]);
endmodule

bind rtc_status_wel rtc_status_wel_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en_i), .wr_data_i(wr_data_i),
  .rd_done_i(rd_done_i), .alarm_match_i(alarm_match_i), .cold_boot_i(cold_boot_i),
  .rtc_wr_i(rtc_wr_i), .rd_data_o(rd_data_o), .mem_wr_ok_o(mem_wr_ok_o),
  .ctl_wr_ok_o(ctl_wr_ok_o)
);

// File: tb/rtc_status_wel_bench.sv
module rtc_status_wel_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en_i = 1'b0;
  logic [7:0] wr_data_i = 8'h00;
  logic       rd_start_i = 1'b0;
  logic       rd_done_i = 1'b0;
  logic [1:0] alarm_match_i = 2'b00;
  logic       on_backup_i = 1'b0;
  logic       cold_boot_i = 1'b0;
  logic       rtc_wr_i = 1'b0;
  logic [7:0] rd_data_o;
  logic       mem_wr_ok_o, ctl_wr_ok_o;

  int checks = 0;
  int fails = 0;
  logic       m_wel = 0, m_rwel = 0, m_fail = 0;
  logic [1:0] m_al = 0, m_mask = 0;

  always #4 clk = ~clk;

  rtc_status_wel u_rtc_status_wel (
    .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en_i), .wr_data_i(wr_data_i),
    .rd_start_i(rd_start_i), .rd_done_i(rd_done_i), .alarm_match_i(alarm_match_i),
    .on_backup_i(on_backup_i), .cold_boot_i(cold_boot_i), .rtc_wr_i(rtc_wr_i),
    .rd_data_o(rd_data_o), .mem_wr_ok_o(mem_wr_ok_o), .ctl_wr_ok_o(ctl_wr_ok_o)
  );

  function automatic logic [7:0] exp_byte();
    return {on_backup_i, m_al[1], m_al[0], 2'b00, m_rwel, m_wel, m_fail};
  endfunction

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic check_all(string ctx);
    logic [7:0] e;
    e = exp_byte();
    chk({ctx, " R2 backup bit"}, rd_data_o[7], e[7]);
    chk({ctx, " R2 zero bits"}, rd_data_o[4:3], 0);
    chk({ctx, " R3/R4 alarm bits"}, rd_data_o[6:5], e[6:5]);
    chk({ctx, " R7 rwel bit"}, rd_data_o[2], e[2]);
    chk({ctx, " R5 wel bit"}, rd_data_o[1], e[1]);
    chk({ctx, " R11 fail bit"}, rd_data_o[0], e[0]);
    chk({ctx, " R9 mem ok"}, mem_wr_ok_o, m_wel);
    chk({ctx, " R9 ctl ok"}, ctl_wr_ok_o, m_wel & m_rwel);
  endtask

  task automatic cyc(string ctx, logic we, logic [7:0] wd, logic rs, logic rd,
                     logic [1:0] am, logic bk, logic cb, logic rw);
    logic [1:0] clr;
    @(negedge clk);
    wr_en_i = we; wr_data_i = wd; rd_start_i = rs; rd_done_i = rd;
    alarm_match_i = am; on_backup_i = bk; cold_boot_i = cb; rtc_wr_i = rw;
    clr = rd ? m_mask : 2'b00;
    if (cb) m_fail = 1'b1;
    else if (rw && m_wel && m_rwel) m_fail = 1'b0;
    if (cb) begin m_wel = 0; m_rwel = 0; end
    else if (we) begin
      if (wd == 8'h00) begin m_wel = 0; m_rwel = 0; end
      else if (wd == 8'h02) m_wel = 1;
      else if (wd == 8'h04 && m_wel) m_rwel = 1;
    end
    if (rs) m_mask = m_al;
    else if (rd) m_mask = 2'b00;
    m_al = (m_al & ~clr) | am;
    @(posedge clk);
    #1;
    check_all(ctx);
  endtask

  initial begin
    #(8 * 200000);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    #20;
    check_all("R1 reset");
    @(negedge clk);
    rst_n = 1'b1;
    cyc("R1 idle", 0, 0, 0, 0, 0, 0, 0, 0);
    cyc("R7 rwel blocked", 1, 8'h04, 0, 0, 0, 0, 0, 0);
    cyc("R5 set wel", 1, 8'h02, 0, 0, 0, 1, 0, 0);
    cyc("R8 ignored 06", 1, 8'h06, 0, 0, 0, 0, 0, 0);
    cyc("R8 ignored ff", 1, 8'hff, 0, 0, 0, 0, 0, 0);
    cyc("R7 set rwel", 1, 8'h04, 0, 0, 0, 0, 0, 0);
    cyc("R10 cold boot", 0, 0, 0, 0, 0, 0, 1, 0);
    cyc("R11 write w/o enable", 0, 0, 0, 0, 0, 0, 0, 1);
    cyc("R5 wel", 1, 8'h02, 0, 0, 0, 0, 0, 0);
    cyc("R7 rwel", 1, 8'h04, 0, 0, 0, 0, 0, 0);
    cyc("R11 clear fail", 0, 0, 0, 0, 0, 0, 0, 1);
    cyc("R6 clear latches", 1, 8'h00, 0, 0, 0, 0, 0, 0);
    cyc("R3 alarm0", 0, 0, 0, 0, 2'b01, 0, 0, 0);
    cyc("R4 start", 0, 0, 1, 0, 2'b00, 0, 0, 0);
    cyc("R4 alarm1 during read", 0, 0, 0, 0, 2'b10, 0, 0, 0);
    cyc("R4 done", 0, 0, 0, 1, 2'b00, 0, 0, 0);
    cyc("R4 done w/o start", 0, 0, 0, 1, 2'b00, 0, 0, 0);
    cyc("R4 start", 0, 0, 1, 0, 2'b00, 0, 0, 0);
    cyc("R4 done with match", 0, 0, 0, 1, 2'b10, 0, 0, 0);
    for (int i = 0; i < 3000; i++) begin
      logic [7:0] wd;
      case ($urandom % 6)
        0: wd = 8'h00;
        1: wd = 8'h02;
        2, 3: wd = 8'h04;
        4: wd = 8'h06;
        default: wd = 8'($urandom);
      endcase
      cyc("random", ($urandom % 4) == 0, wd, ($urandom % 6) == 0, ($urandom % 6) == 0,
          (($urandom % 8) == 0) ? 2'($urandom) : 2'b00, 1'($urandom),
          ($urandom % 64) == 0, ($urandom % 5) == 0);
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule